// File: doc/BRIEF.md
# Serial Port Pin-Function Multiplexer

This block sits between a group of chip pads and three users of them: a general-purpose I/O port, a synchronous serial engine that can run as master or slave, and an asynchronous serial transmitter/receiver. It holds a port data register and a per-pin direction register, both written and read over a simple register bus. From the serial enable, the master/slave mode, the transmitter and receiver enables and the direction bits, it works out each pad's output value and output enable. It also decides what each serial engine input sees.

The meaning of a direction bit depends on the mode. On a pad owned by the synchronous engine it selects whether the serial function is used or disabled, and the choice is not the same in master and in slave mode. It no longer sets a plain input or output. The slave-select pad is active low and passes through a two-flop synchroniser. If it is asserted in master mode while configured as an input, a sticky mode-fault flag is raised. Software clears the flag by writing 1 to it.

Pad bit order, which is also the bit order in the port data and direction registers: 0 master-in/slave-out, 1 master-out/slave-in, 2 serial clock, 3 chip-select 0 / slave-select, 4 to 3+NUM_CS-1 further chip-selects, then the transmit pad, then the receive pad. With the default NUM_CS=4 this gives 9 pads, with transmit at bit 7 and receive at bit 8. Register addresses: 0 is port data (writes latch the data, reads return the pad levels), 1 is direction, 2 is status (bit 0 is the mode fault, write 1 to clear).

Top module: `spm_pinmux`

## Requirements
- R1: After reset the direction register reads 0, the status reads 0, the data register is 0, and the only pad enabled for output is the transmit pad (bit 7), which drives 0.
- R2: A pad not claimed by a peripheral has pad_oe equal to its direction bit. Every pad not driven by a peripheral shows its data-register bit on pad_out, so data written while the pad is still an input appears once the direction bit is set.
- R3: A read of address 0 returns the live pad_in levels, not the latched data. A read of address 1 returns the direction register.
- R4: The transmit pad always has pad_oe=1 and carries sci_txd when sci_tx_en=1, otherwise its data bit. The receive pad never has pad_oe=1. sci_rxd equals the receive pad when sci_rx_en=1, otherwise 0.
- R5: With spi_en=1, pad 0 in master mode is read into spi_sdi when its direction bit is 0 and ignored when it is 1. In slave mode it drives spi_sdo when its direction bit is 1 and is not driven when it is 0.
- R6: With spi_en=1, pad 1 in master mode drives spi_sdo when its direction bit is 1 and is not driven when it is 0. In slave mode it is read into spi_sdi when its direction bit is 0 and ignored when it is 1.
- R7: With spi_en=1, pad 2 drives spi_sck_out in master mode and is read into spi_sck_in in slave mode, whatever its direction bit. With spi_en=0 it is general-purpose I/O and spi_sck_in is 0.
- R8: With spi_en=1, pad 3 in master mode drives spi_cs_out[0] when its direction bit is 1. In slave mode with direction bit 0, spi_ss_n follows the pad two clock edges after it changes. In every other case spi_ss_n is 1.
- R9: With spi_en=1, pads 4 to 6 drive spi_cs_out[1..3] in master mode when their direction bit is 1. They are not driven when the bit is 0, and they are never driven in slave mode.
- R10: In master mode with spi_en=1 and pad 3 direction bit 0, a low level on pad 3 sets mode_fault on the third clock edge after the change. The flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R11: With spi_en=0, spi_sdi is 0 and all serial pads follow R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 status) |
| bus_wdata | input | NUM_CS+5 | Write data |
| bus_rdata | output | NUM_CS+5 | Read data for bus_addr (combinational) |
| spi_en | input | 1 | Synchronous serial engine enable |
| spi_master | input | 1 | 1 = master mode, 0 = slave mode |
| sci_tx_en | input | 1 | Asynchronous transmitter enable |
| sci_rx_en | input | 1 | Asynchronous receiver enable |
| spi_sdo | input | 1 | Serial data from the synchronous engine |
| spi_sck_out | input | 1 | Serial clock from the engine (master) |
| spi_cs_out | input | NUM_CS | Chip-select levels from the engine |
| sci_txd | input | 1 | Transmit data from the asynchronous transmitter |
| spi_sdi | output | 1 | Serial data into the synchronous engine |
| spi_sck_in | output | 1 | Serial clock into the engine (slave) |
| spi_ss_n | output | 1 | Synchronised slave select into the engine, active low |
| sci_rxd | output | 1 | Receive data into the asynchronous receiver |
| mode_fault | output | 1 | Sticky mode-fault flag |
| pad_in | input | NUM_CS+5 | Levels present on the pads |
| pad_out | output | NUM_CS+5 | Pad output values |
| pad_oe | output | NUM_CS+5 | Pad output enables |

## Verification
On every cycle the assertions check the fixed pad roles: the transmit pad always drives, the receive pad never does, the clock pad follows the engine in master mode, and slave mode never drives the extra chip-selects. They also check that a disabled engine sees idle inputs and that the mode-fault flag only rises in master mode and stays set without a clear. The bench's scenarios are needed for the full direction-bit mapping under each mode, for the preload of data before a direction change, for the three-edge latency of the fault, for the two-edge latency of the slave select, and for reads returning pad levels instead of the latched data.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        ADDR_PORT = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic en;
        logic master;
        logic tx_en;
        logic rx_en;
    } link_cfg_t;

    localparam int SYNC_PINS = 3;

endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spm_regs.sv
module spm_regs
    import spm_pkg::*;
#(
    parameter int NP = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  reg_addr_e     addr,
    input  logic [NP-1:0] wdata,
    input  logic          fault_set,
    input  logic [NP-1:0] pad_in,
    output logic [NP-1:0] data_q,
    output logic [NP-3:0] dir_spi,
    output logic          fault_q,
    output logic [NP-1:0] rdata
);
    typedef struct packed {
        logic [NP-1:0] data;
        logic [NP-1:0] dir;
        logic          fault;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && addr == ADDR_PORT) st_d.data = wdata;
        if (wr && addr == ADDR_DIR)  st_d.dir  = wdata;
        if (wr && addr == ADDR_STAT && wdata[0]) st_d.fault = 1'b0;
        if (fault_set) st_d.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            ADDR_PORT: rdata = pad_in;
            ADDR_DIR:  rdata = st_q.dir;
            ADDR_STAT: rdata = {{(NP-1){1'b0}}, st_q.fault};
            default:   rdata = '0;
        endcase
    end

    assign data_q  = st_q.data;
    assign dir_spi = st_q.dir[NP-3:0];
    assign fault_q = st_q.fault;
endmodule

// File: rtl/spm_route.sv
module spm_route
    import spm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  link_cfg_t             cfg,
    input  logic [NUM_CS+4:0]     data_q,
    input  logic [NUM_CS+2:0]     dir_spi,
    input  logic [SYNC_PINS-1:0]  pad_lo,
    input  logic                  pad_rxd,
    input  logic                  ss_sync,
    input  logic                  spi_sdo,
    input  logic                  spi_sck_out,
    input  logic [NUM_CS-1:0]     spi_cs_out,
    input  logic                  sci_txd,
    output logic [NUM_CS+4:0]     pad_out,
    output logic [NUM_CS+4:0]     pad_oe,
    output logic                  spi_sdi,
    output logic                  spi_sck_in,
    output logic                  spi_ss_n,
    output logic                  sci_rxd
);
    localparam int NP     = NUM_CS + 5;
    localparam int NSPI   = SYNC_PINS + NUM_CS;
    localparam int IDX_CS = SYNC_PINS;
    localparam int IDX_TX = NSPI;
    localparam int IDX_RX = NSPI + 1;

    logic [NUM_CS-1:0] cs_drv;
    logic [NSPI-1:0]   spi_drv;
    logic [NSPI-1:0]   spi_val;
    logic              claim;
    logic              mst;

    assign claim = cfg.en;
    assign mst   = cfg.master;

    // one chip-select pad per engine select line
    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign cs_drv[k] = claim & mst & dir_spi[IDX_CS+k];
    end

    always_comb begin
        spi_drv = {cs_drv, claim & mst,
                   claim & mst & dir_spi[1],
                   claim & ~mst & dir_spi[0]};
        spi_val = {spi_cs_out, spi_sck_out, spi_sdo, spi_sdo};
    end

    always_comb begin
        for (int i = 0; i < NSPI; i++) begin
            pad_oe[i]  = claim ? spi_drv[i] : dir_spi[i];
            pad_out[i] = spi_drv[i] ? spi_val[i] : data_q[i];
        end
        pad_oe[IDX_TX]  = 1'b1;
        pad_out[IDX_TX] = cfg.tx_en ? sci_txd : data_q[IDX_TX];
        pad_oe[IDX_RX]  = 1'b0;
        pad_out[IDX_RX] = data_q[IDX_RX];
    end

    always_comb begin
        spi_sdi    = 1'b0;
        spi_sck_in = 1'b0;
        spi_ss_n   = 1'b1;
        if (claim) begin
            if (mst) begin
                spi_sdi = ~dir_spi[0] & pad_lo[0];
            end else begin
                spi_sdi    = ~dir_spi[1] & pad_lo[1];
                spi_sck_in = pad_lo[2];
                spi_ss_n   = dir_spi[IDX_CS] | ss_sync;
            end
        end
        sci_rxd = cfg.rx_en & pad_rxd;
    end

    logic unused_np;
    assign unused_np = (NP > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/spm_pinmux.sv
module spm_pinmux
    import spm_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int NP    = NUM_CS + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [NP-1:0]     bus_wdata,
    output logic [NP-1:0]     bus_rdata,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              sci_tx_en,
    input  logic              sci_rx_en,
    input  logic              spi_sdo,
    input  logic              spi_sck_out,
    input  logic [NUM_CS-1:0] spi_cs_out,
    input  logic              sci_txd,
    output logic              spi_sdi,
    output logic              spi_sck_in,
    output logic              spi_ss_n,
    output logic              sci_rxd,
    output logic              mode_fault,
    input  logic [NP-1:0]     pad_in,
    output logic [NP-1:0]     pad_out,
    output logic [NP-1:0]     pad_oe
);
    localparam int IDX_CS = SYNC_PINS;
    localparam int IDX_RX = NP - 1;

    link_cfg_t     cfg;
    logic [NP-1:0] data_q;
    logic [NP-3:0] dir_spi;
    logic          ss_sync;
    logic          fault_set;

    assign cfg = '{en: spi_en, master: spi_master, tx_en: sci_tx_en, rx_en: sci_rx_en};

    spm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ss_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in[IDX_CS]),
        .dout (ss_sync)
    );

    assign fault_set = spi_en & spi_master & ~dir_spi[IDX_CS] & ~ss_sync;

    spm_regs #(.NP(NP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (reg_addr_e'(bus_addr)),
        .wdata    (bus_wdata),
        .fault_set(fault_set),
        .pad_in   (pad_in),
        .data_q   (data_q),
        .dir_spi  (dir_spi),
        .fault_q  (mode_fault),
        .rdata    (bus_rdata)
    );

    spm_route #(.NUM_CS(NUM_CS)) u_route (
        .cfg        (cfg),
        .data_q     (data_q),
        .dir_spi    (dir_spi),
        .pad_lo     (pad_in[SYNC_PINS-1:0]),
        .pad_rxd    (pad_in[IDX_RX]),
        .ss_sync    (ss_sync),
        .spi_sdo    (spi_sdo),
        .spi_sck_out(spi_sck_out),
        .spi_cs_out (spi_cs_out),
        .sci_txd    (sci_txd),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .spi_sdi    (spi_sdi),
        .spi_sck_in (spi_sck_in),
        .spi_ss_n   (spi_ss_n),
        .sci_rxd    (sci_rxd)
    );
endmodule

// File: rtl/spm_pinmux_chk.sv
module spm_pinmux_chk #(
    parameter int NUM_CS = 4,
    localparam int NP    = NUM_CS + 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [NP-1:0] bus_wdata,
    input logic          spi_en,
    input logic          spi_master,
    input logic          spi_sck_out,
    input logic          spi_sdi,
    input logic          spi_sck_in,
    input logic          spi_ss_n,
    input logic          mode_fault,
    input logic [NP-1:0] pad_out,
    input logic [NP-1:0] pad_oe
);
    localparam int IDX_TX = NUM_CS + 3;
    localparam int IDX_RX = NUM_CS + 4;

    logic clear_wr;
    assign clear_wr = bus_wr && bus_addr == 2'd2 && bus_wdata[0];

    AST_TX_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[IDX_TX]) else $error("tx pad not driven"); // R4

    AST_RX_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IDX_RX]) else $error("rx pad driven"); // R4

    AST_MASTER_CLOCK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> (pad_oe[2] && pad_out[2] == spi_sck_out && !spi_sck_in))
        else $error("master clock pad wrong"); // R7

    AST_SLAVE_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (pad_oe[IDX_TX-1:4] == '0))
        else $error("slave drives chip-select"); // R9

    AST_IDLE_ENGINE_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (!spi_sdi && !spi_sck_in && spi_ss_n))
        else $error("disabled engine sees activity"); // R11

    AST_SS_ONLY_IN_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_master |-> spi_ss_n) else $error("slave select in master"); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !clear_wr) |=> mode_fault) else $error("fault dropped"); // R10

    AST_FAULT_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> $past(spi_en && spi_master))
        else $error("fault outside master"); // R10
endmodule

bind spm_pinmux spm_pinmux_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .spi_sck_out(spi_sck_out),
    .spi_sdi    (spi_sdi),
    .spi_sck_in (spi_sck_in),
    .spi_ss_n   (spi_ss_n),
    .mode_fault (mode_fault),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/tb_spm_pinmux.sv
`timescale 1ns/1ps
module tb_spm_pinmux;
    localparam int NCS = 4;
    localparam int NP  = NCS + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic spi_en = 0, spi_master = 0, sci_tx_en = 0, sci_rx_en = 0;
    logic spi_sdo = 0, spi_sck_out = 0, sci_txd = 0;
    logic [NCS-1:0] spi_cs_out = '0;
    logic spi_sdi, spi_sck_in, spi_ss_n, sci_rxd, mode_fault;
    logic [NP-1:0] pad_in = '1;
    logic [NP-1:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NP-1:0] m_data = '0;
    logic [NP-1:0] m_dir  = '0;

    always #2 clk = ~clk;

    spm_pinmux #(.NUM_CS(NCS)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_data = d;
        if (a == 2'd1) m_dir = d;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // expected pad and engine-side values, assuming pad_in settled
    task automatic model(output logic [NP-1:0] eo, output logic [NP-1:0] eoe,
                         output logic esdi, output logic esck, output logic essn,
                         output logic erxd);
        logic [NP-1:0] drv;
        logic [NP-1:0] val;
        drv = '0; val = '0;
        eoe = m_dir;
        if (spi_en) begin
            drv[0] = !spi_master && m_dir[0]; val[0] = spi_sdo;
            drv[1] = spi_master && m_dir[1];  val[1] = spi_sdo;
            drv[2] = spi_master;              val[2] = spi_sck_out;
            for (int k = 0; k < NCS; k++) begin
                drv[3+k] = spi_master && m_dir[3+k];
                val[3+k] = spi_cs_out[k];
            end
            eoe[NP-3:0] = drv[NP-3:0];
        end
        drv[NP-2] = sci_tx_en; val[NP-2] = sci_txd;
        eoe[NP-2] = 1'b1;
        eoe[NP-1] = 1'b0;
        for (int i = 0; i < NP; i++) eo[i] = drv[i] ? val[i] : m_data[i];
        esdi = 1'b0; esck = 1'b0; essn = 1'b1;
        if (spi_en) begin
            if (spi_master) esdi = !m_dir[0] && pad_in[0];
            else begin
                esdi = !m_dir[1] && pad_in[1];
                esck = pad_in[2];
                essn = m_dir[3] || pad_in[3];
            end
        end
        erxd = sci_rx_en && pad_in[NP-1];
    endtask

    initial begin
        logic [NP-1:0] rd;
        logic [NP-1:0] eo, eoe;
        logic esdi, esck, essn, erxd;
        int seed_val;
        seed_val = $urandom(32'h5a17);

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(2'd1, rd); chk("R1 dir after reset", rd, 0);
        rd_reg(2'd2, rd); chk("R1 status after reset", rd, 0);
        chk("R1 oe after reset", pad_oe, 9'h080);
        chk("R1 out after reset", pad_out, 0);
        chk("R1 fault after reset", mode_fault, 0);

        // preload while inputs, then turn to outputs
        wr_reg(2'd0, 9'h155);
        chk("R2 preload does not drive", pad_oe, 9'h080);
        chk("R2 preload latched", pad_out, 9'h155);
        wr_reg(2'd1, 9'h1FF);
        chk("R2 outputs after dir set", pad_oe, 9'h0FF);
        chk("R2 data on pads", pad_out, 9'h155);
        chk("R4 rx pad not driven", pad_oe[8], 0);
        pad_in = 9'h0C3;
        rd_reg(2'd0, rd); chk("R3 read returns pad levels", rd, 9'h0C3);
        rd_reg(2'd1, rd); chk("R3 read returns dir", rd, 9'h1FF);

        // mode fault timing, stickiness and clear
        pad_in = '1;
        spi_en = 1; spi_master = 1;
        wr_reg(2'd1, 9'h000);
        wait_n(3);
        chk("R10 no fault with ss high", mode_fault, 0);
        pad_in[3] = 1'b0;
        @(negedge clk); chk("R10 fault edge 1", mode_fault, 0);
        @(negedge clk); chk("R10 fault edge 2", mode_fault, 0);
        @(negedge clk); chk("R10 fault edge 3", mode_fault, 1);
        pad_in[3] = 1'b1;
        wait_n(4);
        chk("R10 fault sticky", mode_fault, 1);
        rd_reg(2'd2, rd); chk("R10 status reads fault", rd, 1);
        wr_reg(2'd2, 9'h000);
        chk("R10 write 0 keeps fault", mode_fault, 1);
        wr_reg(2'd2, 9'h001);
        chk("R10 write 1 clears fault", mode_fault, 0);

        // master with chip-select output: no fault, pad drives select
        spi_cs_out = 4'b0001;
        wr_reg(2'd1, 9'h008);
        pad_in[3] = 1'b0;
        wait_n(4);
        chk("R8 cs output no fault", mode_fault, 0);
        chk("R8 cs0 driven", pad_oe[3], 1);
        chk("R8 cs0 level", pad_out[3], 1);
        pad_in[3] = 1'b1;

        // slave select latency
        spi_master = 0;
        wr_reg(2'd1, 9'h000);
        wait_n(3);
        chk("R8 ss idle", spi_ss_n, 1);
        pad_in[3] = 1'b0;
        @(negedge clk); chk("R8 ss after edge 1", spi_ss_n, 1);
        @(negedge clk); chk("R8 ss after edge 2", spi_ss_n, 0);
        chk("R10 no fault in slave", mode_fault, 0);

        // constrained random mapping
        for (int it = 0; it < 250; it++) begin
            @(negedge clk);
            spi_en = ($urandom_range(0, 3) != 0);
            spi_master = $urandom_range(0, 1);
            sci_tx_en = $urandom_range(0, 1);
            sci_rx_en = $urandom_range(0, 1);
            spi_sdo = $urandom_range(0, 1);
            spi_sck_out = $urandom_range(0, 1);
            spi_cs_out = NCS'($urandom);
            sci_txd = $urandom_range(0, 1);
            pad_in = NP'($urandom);
            wr_reg(2'd0, NP'($urandom));
            wr_reg(2'd1, NP'($urandom));
            wait_n(2);
            model(eo, eoe, esdi, esck, essn, erxd);
            chk("R2 R4 R5 R6 R7 R8 R9 pad_oe", pad_oe, eoe);
            chk("R2 R4 R5 R6 R7 R8 R9 pad_out", pad_out, eo);
            chk("R5 R6 R11 spi_sdi", spi_sdi, esdi);
            chk("R7 spi_sck_in", spi_sck_in, esck);
            chk("R8 spi_ss_n", spi_ss_n, essn);
            chk("R4 sci_rxd", sci_rxd, erxd);
            rd_reg(2'd0, rd); chk("R3 pad read", rd, pad_in);
            rd_reg(2'd1, rd); chk("R3 dir read", rd, m_dir);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule